// File: doc/BRIEF.md
# Four-Way Set-Associative Write-Back Cache

This block sits between a processor-side word port and a slower external memory port. It keeps recently used 16-byte lines in a four-way set-associative array and answers reads and writes that hit from the array in one clock. A read miss picks the least recently used way of the set. If that line holds modified words, those words go back to memory first. Then the new line is fetched one word at a time.

A write that misses is sent straight to memory and allocates nothing. A write that hits goes one of two ways, chosen by a level input sampled with each request. In write-back operation only the cached word is updated, and that word is marked modified. In write-through operation the cached word is updated and memory is updated too, and the processor waits for the memory acknowledge. Modified state is kept for each 32-bit word, so write-back traffic covers only the words that actually changed.

A flush input walks every line and writes back its modified words. It then invalidates the whole array and reports completion with a one-cycle flag. The number of sets is a parameter. The default of 128 sets gives 8 KB; a simulation can use a few sets.

Top module: `wbc_cache`

## Requirements
- R1: A read that hits returns the cached word with `cpu_ready` high in the cycle after the request is accepted, and no memory access is made.
- R2: A read miss fetches the four words of the line at offsets 0, 1, 2, 3 in that order, returns the requested word, and leaves the line valid so that a repeat read hits.
- R3: A write miss performs one memory write at the request address and allocates no line, so a later read of that address misses and returns the written data from memory.
- R4: With `wt_mode`=0, a write hit updates only the cached word, sets its modified bit and completes in one cycle; memory keeps its old value.
- R5: With `wt_mode`=1, a write hit updates the cached word and memory, completes only after `mem_ack`, and sets no modified bit.
- R6: The victim on a read miss is the least recently used way of the set; every hit and every completed fill makes that way the most recently used.
- R7: Replacing a line writes back only its modified words, each to its own word address, before the new line is fetched; a clean victim causes no memory write.
- R8: A flush request, taken when no access is in progress and ahead of a waiting processor request, writes back every modified word of every valid line, then invalidates all lines and raises `flush_done` for one cycle.
- R9: Once `mem_req` is raised, it stays high until `mem_ack`, and `mem_addr`, `mem_we` and `mem_wdata` stay unchanged while it waits.
- R10: After reset `cpu_ready`, `flush_done` and `mem_req` are low and every line is invalid.
- R11: `cpu_ready` and `flush_done` are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wt_mode | input | 1 | 1 = write-through on write hits, 0 = write-back |
| cpu_req | input | 1 | Request valid, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Word address: offset in bits [1:0], set index above it, tag at the top |
| cpu_wdata | input | DW | Write data |
| cpu_rdata | output | DW | Read data, valid while `cpu_ready` is high |
| cpu_ready | output | 1 | One-cycle completion pulse |
| flush_req | input | 1 | Flush request, held until `flush_done` |
| flush_done | output | 1 | One-cycle flush completion pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory completion, one cycle |

## Verification
The bench builds the cache with four sets and a 10-bit word address. With only four sets, one set's four ways fill after a handful of reads. That is enough to walk the replacement order through several evictions: first a clean victim, then a victim holding a single modified word. With sixteen lines in total, a flush visits the whole array in well under a hundred cycles. The memory model acknowledges after a wait of two cycles, so request hold and the write-through stall can be observed at the ports.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,   // waiting for a request
    ST_MWR,    // single memory write on behalf of the processor
    ST_WB,     // writing modified words of a line back
    ST_FILL    // fetching a line from memory
  } wbc_state_e;
endpackage

// File: rtl/wbc_lru.sv
// Per-set recency ordering: rank 0 holds the most recent way, the last rank the victim.
module wbc_lru #(
  parameter int SETS = 128,
  parameter int WAYS = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [$clog2(SETS)-1:0]  look_set,
  output logic [$clog2(WAYS)-1:0]  victim,
  input  logic                     touch_en,
  input  logic [$clog2(SETS)-1:0]  touch_set,
  input  logic [$clog2(WAYS)-1:0]  touch_way
);
  localparam int WW = $clog2(WAYS);

  logic [WAYS-1:0][WW-1:0] ord_q [SETS];
  logic [WAYS-1:0][WW-1:0] cur;
  logic [WAYS-1:0][WW-1:0] nxt;

  assign victim = ord_q[look_set][WAYS-1];
  assign cur    = ord_q[touch_set];

  always_comb begin
    int p;
    p = 0;
    for (int k = 0; k < WAYS; k++)
      if (cur[k] == touch_way) p = k;
    nxt[0] = touch_way;
    for (int k = 1; k < WAYS; k++)
      nxt[k] = (k <= p) ? cur[k-1] : cur[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++)
        for (int k = 0; k < WAYS; k++)
          ord_q[s][k] <= WW'(k);
    end else if (touch_en) begin
      ord_q[touch_set] <= nxt;
    end
  end
endmodule

// File: rtl/wbc_data.sv
// Line data store: one write port, one asynchronous read port.
module wbc_data #(
  parameter int SETS       = 128,
  parameter int WAYS       = 4,
  parameter int LINE_WORDS = 4,
  parameter int DW         = 32
) (
  input  logic                           clk,
  input  logic                           we,
  input  logic [$clog2(SETS)-1:0]        w_set,
  input  logic [$clog2(WAYS)-1:0]        w_way,
  input  logic [$clog2(LINE_WORDS)-1:0]  w_word,
  input  logic [DW-1:0]                  w_data,
  input  logic [$clog2(SETS)-1:0]        r_set,
  input  logic [$clog2(WAYS)-1:0]        r_way,
  input  logic [$clog2(LINE_WORDS)-1:0]  r_word,
  output logic [DW-1:0]                  r_data
);
  localparam int DEPTH = SETS * WAYS * LINE_WORDS;
  localparam int XW    = $clog2(DEPTH);

  logic [DW-1:0] store [DEPTH];
  logic [XW-1:0] waddr, raddr;

  assign waddr  = {w_set, w_way, w_word};
  assign raddr  = {r_set, r_way, r_word};
  assign r_data = store[raddr];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= w_data;
  end
endmodule

// File: rtl/wbc_cache.sv
module wbc_cache
  import wbc_pkg::*;
#(
  parameter int AW         = 30,
  parameter int DW         = 32,
  parameter int SETS       = 128,
  parameter int WAYS       = 4,
  parameter int LINE_WORDS = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wt_mode,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          cpu_ready,
  input  logic          flush_req,
  output logic          flush_done,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ack
);
  localparam int IW = $clog2(SETS);
  localparam int OW = $clog2(LINE_WORDS);
  localparam int WW = $clog2(WAYS);
  localparam int TW = AW - IW - OW;
  localparam logic [OW-1:0] LAST_WORD = OW'(LINE_WORDS - 1);
  localparam logic [IW-1:0] LAST_SET  = IW'(SETS - 1);
  localparam logic [WW-1:0] LAST_WAY  = WW'(WAYS - 1);

  wbc_state_e state;

  // Line state: tags and modified bits are not reset, valid bits gate both.
  logic [TW-1:0]         tag_q [SETS][WAYS];
  logic [LINE_WORDS-1:0] dty_q [SETS][WAYS];
  logic [WAYS-1:0]       vld_q [SETS];

  logic [AW-1:0] r_addr;
  logic [WW-1:0] r_way;
  logic [IW-1:0] wb_set;
  logic [WW-1:0] wb_way;
  logic [OW-1:0] wcnt;
  logic          flushing;

  // Request decode
  logic [OW-1:0] c_off, r_off;
  logic [IW-1:0] c_idx, r_idx;
  logic [TW-1:0] c_tag, r_tag;
  assign c_off = cpu_addr[OW-1:0];
  assign c_idx = cpu_addr[OW +: IW];
  assign c_tag = cpu_addr[AW-1 -: TW];
  assign r_off = r_addr[OW-1:0];
  assign r_idx = r_addr[OW +: IW];
  assign r_tag = r_addr[AW-1 -: TW];

  // Tag compare across the ways of the addressed set
  logic [WAYS-1:0] way_hit;
  logic            hit_any;
  logic [WW-1:0]   hit_way;
  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign way_hit[g] = vld_q[c_idx][g] && (tag_q[c_idx][g] == c_tag);
  end
  assign hit_any = |way_hit;
  always_comb begin
    hit_way = '0;
    for (int g = 0; g < WAYS; g++)
      if (way_hit[g]) hit_way = WW'(g);
  end

  // Acceptance and step conditions
  logic idle_free, go_flush, go_cpu, rd_hit, wr_hit, wr_miss, rd_miss;
  logic mem_done, fill_last, wb_need, wb_step, wb_line_last;
  assign idle_free = (state == ST_IDLE) && !cpu_ready && !flush_done;
  assign go_flush  = idle_free && flush_req;
  assign go_cpu    = idle_free && !flush_req && cpu_req;
  assign rd_hit    = go_cpu && !cpu_we && hit_any;
  assign wr_hit    = go_cpu &&  cpu_we && hit_any;
  assign wr_miss   = go_cpu &&  cpu_we && !hit_any;
  assign rd_miss   = go_cpu && !cpu_we && !hit_any;
  assign mem_done  = mem_req && mem_ack;
  assign fill_last = (state == ST_FILL) && mem_done && (wcnt == LAST_WORD);
  assign wb_need   = vld_q[wb_set][wb_way] && dty_q[wb_set][wb_way][wcnt];
  assign wb_step   = (state == ST_WB) && ((!mem_req && !wb_need) || mem_done);
  assign wb_line_last = (wb_set == LAST_SET) && (wb_way == LAST_WAY);

  // Replacement order
  logic [WW-1:0] vict_way;
  logic          touch_en;
  assign touch_en = rd_hit || wr_hit || fill_last;

  wbc_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
    .clk       (clk),
    .rst       (rst),
    .look_set  (c_idx),
    .victim    (vict_way),
    .touch_en  (touch_en),
    .touch_set ((state == ST_FILL) ? r_idx : c_idx),
    .touch_way ((state == ST_FILL) ? r_way : hit_way)
  );

  // Line data
  logic          d_we;
  logic [DW-1:0] d_rdata;
  assign d_we = wr_hit || ((state == ST_FILL) && mem_done);

  wbc_data #(.SETS(SETS), .WAYS(WAYS), .LINE_WORDS(LINE_WORDS), .DW(DW)) u_data (
    .clk    (clk),
    .we     (d_we),
    .w_set  ((state == ST_FILL) ? r_idx : c_idx),
    .w_way  ((state == ST_FILL) ? r_way : hit_way),
    .w_word ((state == ST_FILL) ? wcnt  : c_off),
    .w_data ((state == ST_FILL) ? mem_rdata : cpu_wdata),
    .r_set  ((state == ST_WB) ? wb_set : c_idx),
    .r_way  ((state == ST_WB) ? wb_way : hit_way),
    .r_word ((state == ST_WB) ? wcnt   : c_off),
    .r_data (d_rdata)
  );

  // Control sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cpu_ready  <= 1'b0;
      cpu_rdata  <= '0;
      flush_done <= 1'b0;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      r_addr     <= '0;
      r_way      <= '0;
      wb_set     <= '0;
      wb_way     <= '0;
      wcnt       <= '0;
      flushing   <= 1'b0;
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else begin
      cpu_ready  <= 1'b0;
      flush_done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (go_flush) begin
            flushing <= 1'b1;
            wb_set   <= '0;
            wb_way   <= '0;
            wcnt     <= '0;
            state    <= ST_WB;
          end else if (go_cpu) begin
            r_addr <= cpu_addr;
            if (rd_hit) begin
              cpu_rdata <= d_rdata;
              cpu_ready <= 1'b1;
            end else if (wr_hit && !wt_mode) begin
              dty_q[c_idx][hit_way][c_off] <= 1'b1;
              cpu_ready <= 1'b1;
            end else if (cpu_we) begin
              mem_req   <= 1'b1;
              mem_we    <= 1'b1;
              mem_addr  <= cpu_addr;
              mem_wdata <= cpu_wdata;
              state     <= ST_MWR;
            end else if (rd_miss) begin
              r_way    <= vict_way;
              wcnt     <= '0;
              flushing <= 1'b0;
              wb_set   <= c_idx;
              wb_way   <= vict_way;
              state    <= (vld_q[c_idx][vict_way] && (|dty_q[c_idx][vict_way]))
                          ? ST_WB : ST_FILL;
            end
          end
        end
        ST_MWR: begin
          if (mem_done) begin
            mem_req   <= 1'b0;
            mem_we    <= 1'b0;
            cpu_ready <= 1'b1;
            state     <= ST_IDLE;
          end
        end
        ST_WB: begin
          if (!mem_req && wb_need) begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= {tag_q[wb_set][wb_way], wb_set, wcnt};
            mem_wdata <= d_rdata;
          end else if (mem_done) begin
            mem_req <= 1'b0;
            mem_we  <= 1'b0;
          end
          if (wb_step) begin
            if (wcnt != LAST_WORD) begin
              wcnt <= wcnt + OW'(1);
            end else begin
              wcnt <= '0;
              if (!flushing) begin
                state <= ST_FILL;
              end else if (wb_line_last) begin
                for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
                flushing   <= 1'b0;
                flush_done <= 1'b1;
                state      <= ST_IDLE;
              end else if (wb_way == LAST_WAY) begin
                wb_way <= '0;
                wb_set <= wb_set + IW'(1);
              end else begin
                wb_way <= wb_way + WW'(1);
              end
            end
          end
        end
        ST_FILL: begin
          if (!mem_req) begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= {r_tag, r_idx, wcnt};
          end else if (mem_ack) begin
            mem_req <= 1'b0;
            if (wcnt == r_off) cpu_rdata <= mem_rdata;
            if (wcnt == LAST_WORD) begin
              tag_q[r_idx][r_way] <= r_tag;
              vld_q[r_idx][r_way] <= 1'b1;
              dty_q[r_idx][r_way] <= '0;
              cpu_ready <= 1'b1;
              wcnt      <= '0;
              state     <= ST_IDLE;
            end else begin
              wcnt <= wcnt + OW'(1);
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wbc_cache_chk.sv
module wbc_cache_chk #(
  parameter int AW = 30,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          wt_mode,
  input logic          cpu_ready,
  input logic          flush_done,
  input logic          mem_req,
  input logic          mem_ack,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          rd_hit,
  input logic          wr_hit,
  input logic          wr_miss
);
  // R1: an accepted read hit completes in the next cycle
  p_read_hit_r1: assert property (@(posedge clk) disable iff (rst)
    rd_hit |=> cpu_ready);

  // R3: a write miss turns into a memory write
  p_write_miss_r3: assert property (@(posedge clk) disable iff (rst)
    wr_miss |=> (mem_req && mem_we && !cpu_ready));

  // R4: write-back hit finishes at once with no memory traffic
  p_wb_hit_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && !wt_mode) |=> (cpu_ready && !mem_req));

  // R5: write-through hit waits for the memory write
  p_wt_hit_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && wt_mode) |=> (mem_req && mem_we && !cpu_ready));

  // R9: request and its fields hold until acknowledged
  p_mem_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata)));

  // R11: completion flags are single-cycle pulses
  p_ready_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready);
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    flush_done |=> !flush_done);
endmodule

bind wbc_cache wbc_cache_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wt_mode    (wt_mode),
  .cpu_ready  (cpu_ready),
  .flush_done (flush_done),
  .mem_req    (mem_req),
  .mem_ack    (mem_ack),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .rd_hit     (rd_hit),
  .wr_hit     (wr_hit),
  .wr_miss    (wr_miss)
);

// File: tb/tb_wbc_cache.sv
`timescale 1ns/1ps
module tb_wbc_cache;
  localparam int AW = 10;
  localparam int DW = 32;
  localparam int MW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wt_mode = 1'b0;
  logic          cpu_req = 1'b0;
  logic          cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic [DW-1:0] cpu_rdata;
  logic          cpu_ready;
  logic          flush_req = 1'b0;
  logic          flush_done;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic          mem_ack = 1'b0;

  always #10 clk = ~clk;

  wbc_cache #(.AW(AW), .DW(DW), .SETS(4), .WAYS(4), .LINE_WORDS(4)) dut (
    .clk(clk), .rst(rst), .wt_mode(wt_mode),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .flush_req(flush_req), .flush_done(flush_done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  int checks = 0;
  int failures = 0;

  // Memory model: acknowledges after two waiting cycles
  logic [DW-1:0] bmem [MW];
  logic [AW-1:0] rd_log [4];
  int rd_cnt = 0, wr_cnt = 0, wait_m = 0, hold_viol = 0;
  logic [AW-1:0] last_wa, h_addr;
  logic          h_we;
  logic [DW-1:0] h_wd;

  function automatic logic [DW-1:0] init_val(int i);
    return 32'h5A00_0000 ^ (i * 32'h0001_0003);
  endfunction

  function automatic logic [AW-1:0] A(int t, int s, int o);
    return {6'(t), 2'(s), 2'(o)};
  endfunction

  initial for (int i = 0; i < MW; i++) bmem[i] = init_val(i);

  always @(negedge clk) begin
    if (rst) begin
      mem_ack = 1'b0;
      wait_m  = 0;
    end else if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (mem_req) begin
      if (wait_m > 0 && (mem_addr != h_addr || mem_we != h_we || mem_wdata != h_wd))
        hold_viol++;
      h_addr = mem_addr; h_we = mem_we; h_wd = mem_wdata;
      if (wait_m < 2) wait_m++;
      else begin
        wait_m  = 0;
        mem_ack = 1'b1;
        if (mem_we) begin
          bmem[mem_addr] = mem_wdata;
          wr_cnt++;
          last_wa = mem_addr;
        end else begin
          mem_rdata = bmem[mem_addr];
          rd_log[rd_cnt % 4] = mem_addr;
          rd_cnt++;
        end
      end
    end
  end

  // Pulse monitor
  int pulse_viol = 0, done_cnt = 0;
  logic prev_rdy = 1'b0, prev_done = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (cpu_ready && prev_rdy) pulse_viol++;
      if (flush_done && prev_done) pulse_viol++;
      if (flush_done) done_cnt++;
    end
    prev_rdy  = cpu_ready;
    prev_done = flush_done;
  end

  task automatic check(string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic cpu_op(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                        output logic [DW-1:0] rd, output int cyc);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!cpu_ready && cyc < 2000);
    rd = cpu_rdata;
    cpu_req = 1'b0; cpu_we = 1'b0;
  endtask

  // Scenario tasks
  task automatic t_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check("R10 cpu_ready after reset", {31'd0, cpu_ready}, 0);
    check("R10 mem_req after reset", {31'd0, mem_req}, 0);
    check("R10 flush_done after reset", {31'd0, flush_done}, 0);
  endtask

  task automatic t_miss_fill();
    logic [DW-1:0] d; int c; int base;
    base = rd_cnt;
    cpu_op(1'b0, A(1,0,2), '0, d, c);
    check("R10 R2 first read misses", {31'd0, c > 1}, 1);
    check("R2 miss data", d, init_val(A(1,0,2)));
    check("R2 four line reads", rd_cnt - base, 4);
    for (int k = 0; k < 4; k++)
      check("R2 fill word order", {22'd0, rd_log[(base + k) % 4]}, {22'd0, A(1,0,k)});
    base = rd_cnt;
    cpu_op(1'b0, A(1,0,0), '0, d, c);
    check("R1 hit latency", c, 1);
    check("R1 hit data", d, init_val(A(1,0,0)));
    check("R1 no memory access on hit", rd_cnt - base, 0);
  endtask

  task automatic t_wb_write();
    logic [DW-1:0] d; int c; int wb;
    wt_mode = 1'b0;
    wb = wr_cnt;
    cpu_op(1'b1, A(1,0,1), 32'hDEAD_0001, d, c);
    check("R4 write-back hit latency", c, 1);
    check("R4 no memory write", wr_cnt - wb, 0);
    check("R4 memory keeps old value", bmem[A(1,0,1)], init_val(A(1,0,1)));
    cpu_op(1'b0, A(1,0,1), '0, d, c);
    check("R4 cached word updated", d, 32'hDEAD_0001);
  endtask

  task automatic t_write_miss();
    logic [DW-1:0] d; int c; int wb;
    wb = wr_cnt;
    cpu_op(1'b1, A(2,1,0), 32'hBEEF_0002, d, c);
    check("R3 one memory write", wr_cnt - wb, 1);
    check("R3 memory written", bmem[A(2,1,0)], 32'hBEEF_0002);
    cpu_op(1'b0, A(2,1,0), '0, d, c);
    check("R3 no allocation on write miss", {31'd0, c > 1}, 1);
    check("R3 read after write miss", d, 32'hBEEF_0002);
  endtask

  task automatic t_lru_evict();
    logic [DW-1:0] d; int c; int wb;
    for (int t = 2; t <= 4; t++) cpu_op(1'b0, A(t,0,0), '0, d, c);
    cpu_op(1'b0, A(1,0,3), '0, d, c);          // recency: 1,4,3,2
    check("R6 tag1 still resident", c, 1);
    wb = wr_cnt;
    cpu_op(1'b0, A(5,0,0), '0, d, c);          // evicts tag2 (clean)
    check("R7 clean victim writes nothing", wr_cnt - wb, 0);
    cpu_op(1'b0, A(1,0,0), '0, d, c);
    check("R6 recently used line kept", c, 1);
    cpu_op(1'b0, A(2,0,0), '0, d, c);          // evicts tag3
    check("R6 least recent line evicted", {31'd0, c > 1}, 1);
    cpu_op(1'b0, A(3,0,0), '0, d, c);          // evicts tag4
    cpu_op(1'b0, A(4,0,0), '0, d, c);          // evicts tag5
    wb = wr_cnt;
    cpu_op(1'b0, A(6,0,2), '0, d, c);          // evicts tag1 (one modified word)
    check("R7 only modified word written", wr_cnt - wb, 1);
    check("R7 write-back address", {22'd0, last_wa}, {22'd0, A(1,0,1)});
    check("R7 write-back data", bmem[A(1,0,1)], 32'hDEAD_0001);
    check("R7 clean word untouched", bmem[A(1,0,0)], init_val(A(1,0,0)));
    check("R7 new line data", d, init_val(A(6,0,2)));
  endtask

  task automatic t_write_through();
    logic [DW-1:0] d; int c; int wb;
    wt_mode = 1'b1;
    wb = wr_cnt;
    cpu_op(1'b1, A(6,0,2), 32'hCAFE_0003, d, c);
    check("R5 write-through waits for memory", {31'd0, c > 3}, 1);
    check("R5 one memory write", wr_cnt - wb, 1);
    check("R5 memory updated", bmem[A(6,0,2)], 32'hCAFE_0003);
    cpu_op(1'b0, A(6,0,2), '0, d, c);
    check("R5 cache updated", d, 32'hCAFE_0003);
    wt_mode = 1'b0;
  endtask

  task automatic t_flush();
    logic [DW-1:0] d; int c; int wb; int dc; int n;
    cpu_op(1'b1, A(2,0,3), 32'h1234_0004, d, c);
    check("R4 write hit before flush", c, 1);
    cpu_op(1'b1, A(2,1,1), 32'h1234_0005, d, c);
    wb = wr_cnt; dc = done_cnt;
    @(negedge clk);
    flush_req = 1'b1;
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = A(6,0,2);   // waits behind the flush
    n = 0;
    do begin @(negedge clk); n++; end while (!flush_done && !cpu_ready && n < 2000);
    check("R8 flush taken before waiting request", {31'd0, flush_done}, 1);
    flush_req = 1'b0;
    do begin @(negedge clk); n++; end while (!cpu_ready && n < 4000);
    cpu_req = 1'b0;
    check("R8 request after flush misses", cpu_rdata, 32'hCAFE_0003);
    check("R8 R5 exactly the modified words written", wr_cnt - wb, 2);
    check("R8 flushed word set0", bmem[A(2,0,3)], 32'h1234_0004);
    check("R8 flushed word set1", bmem[A(2,1,1)], 32'h1234_0005);
    repeat (3) @(negedge clk);
    check("R8 R11 single done pulse", done_cnt - dc, 1);
    cpu_op(1'b0, A(2,1,1), '0, d, c);
    check("R8 lines invalid after flush", {31'd0, c > 1}, 1);
    check("R8 data after flush", d, 32'h1234_0005);
  endtask

  initial begin
    t_reset();
    t_miss_fill();
    t_wb_write();
    t_write_miss();
    t_lru_evict();
    t_write_through();
    t_flush();
    check("R9 memory request hold", hold_viol, 0);
    check("R11 pulse width", pulse_viol, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule